// File: doc/BRIEF.md
# Centre-Spread Clock Modulation Controller

This block is the digital sweep generator inside a spread-spectrum clock synthesiser. On every reference clock cycle it produces a signed frequency-offset word, in parts per 10,000, for a fractional feedback divider. The offset follows a triangular profile that is symmetric about zero, so the average output frequency stays at the reference frequency. The length of the modulation period is a fixed number of reference cycles, whatever the setting.

Two select inputs carry three-state levels that have already been digitised. Together they pick one of nine settings. Each setting fixes the input-frequency range class (low or high) and the depth of the spread. A two-bit sub-band input then selects the exact peak from a table. The spread-enable input, the select inputs and the sub-band input are sampled only at a period boundary. A setting can therefore never change in the middle of a sweep. A sticky flag records any level code that is not legal.

Top module: `ssc_mod_ctrl`

## Requirements
- R1: An internal phase counter steps through 0..1165 and wraps back to 0, so one modulation period is exactly 1166 reference cycles.
- R2: With the sweep active and peak P, the offset at phase p is -P + floor(2*P*p/583) for p <= 583, and P - floor(2*P*(p-583)/583) for p > 583. Inside a period the offset never moves by more than 1 per cycle.
- R3: The sweep is centred. The offset equals -P at phase 0 and +P at phase 583, and within an active period its minimum is -P and its maximum is +P.
- R4: The peak P in parts per 10,000 is half the total spread. Listed per setting index for sub-bands 0/1/2/3: idx0 215/195/185/170, idx1 190/175/165/155, idx2 170/155/140/130, idx3 145/125/120/110, idx4 140/120/115/105, idx5 145/140/130/120, idx6 105/100/90/85, idx7 75/70/65/60, idx8 60/55/55/50. peak_o shows P.
- R5: The select level codes are 00 = low, 01 = middle and 10 = high. The pairs (sel1_i, sel0_i) decode to setting index 0..8 in this order: (M,M), (M,L), (H,L), (L,L), (L,M), (H,M), (L,H), (H,H), (M,H). hi_range_o is 1 for indices 5..8 and 0 for indices 0..4.
- R6: A code of 11 on either select input is decoded as middle. It also sets code_err_o in the cycle after the edge that sampled it. code_err_o stays set until reset.
- R7: While the latched enable is 0, the offset is 0 for every cycle of the period.
- R8: Enable, select and sub-band inputs are sampled only at the clock edge that moves the phase from 1165 to 0. The first phase-0 cycle shows the new offset and setting, and setting_o, hi_range_o and peak_o hold their values for the rest of the period.
- R9: A synchronous reset clears the phase, the offset and code_err_o. It also loads a disabled configuration with index 0 and sub-band 0 (peak_o = 215). The first period after reset therefore has an offset of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_en_i | input | 1 | Modulation enable, sampled at period boundary |
| sel0_i | input | 2 | Digitised level code of select input 0 |
| sel1_i | input | 2 | Digitised level code of select input 1 |
| band_i | input | 2 | Sub-band choosing the peak within a setting |
| offset_o | output | OFF_W (10) | Signed frequency offset, parts per 10,000 |
| hi_range_o | output | 1 | Latched setting belongs to the high input range |
| setting_o | output | 4 | Latched setting index 0..8 |
| peak_o | output | 9 | Latched peak magnitude in parts per 10,000 |
| code_err_o | output | 1 | Sticky flag for an illegal select code |

## Verification
The bench steps through all nine settings and all four sub-bands. It checks every cycle against the ramp formula, so a period off by one cycle, or an accumulator that rounds the wrong way, would leave the turning point away from +P at phase 583 or the minimum away from -P. Select, sub-band and enable changes are applied in the middle of a sweep. A design that sampled them early would show a wrong setting or a stray offset before the boundary. Illegal codes on each select input are checked for decoding as middle and for a flag that survives later legal codes until a reset in the middle of a run.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int PEAK_W  = 9;
    localparam int SET_W   = 4;
    localparam int BAND_W  = 2;

    typedef enum logic [1:0] {
        TL_LO  = 2'b00,
        TL_MID = 2'b01,
        TL_HI  = 2'b10,
        TL_BAD = 2'b11
    } tl_code_e;

    typedef struct packed {
        logic              en;
        logic              hi;
        logic [SET_W-1:0]  idx;
        logic [BAND_W-1:0] band;
        logic [PEAK_W-1:0] peak;
    } ssc_cfg_t;

    // Unusable code falls back to the level an open pin would give.
    function automatic tl_code_e tl_clean(input logic [1:0] code);
        if (code == 2'b11)
            return TL_MID;
        return tl_code_e'(code);
    endfunction

    function automatic logic [PEAK_W-1:0] pick4(input logic [BAND_W-1:0] b,
                                                input int v0, input int v1,
                                                input int v2, input int v3);
        case (b)
            2'd0:    return PEAK_W'(v0);
            2'd1:    return PEAK_W'(v1);
            2'd2:    return PEAK_W'(v2);
            default: return PEAK_W'(v3);
        endcase
    endfunction

    // Half of the total spread, in parts per 10,000.
    function automatic logic [PEAK_W-1:0] peak_lookup(input logic [SET_W-1:0] idx,
                                                      input logic [BAND_W-1:0] b);
        case (idx)
            4'd0:    return pick4(b, 215, 195, 185, 170);
            4'd1:    return pick4(b, 190, 175, 165, 155);
            4'd2:    return pick4(b, 170, 155, 140, 130);
            4'd3:    return pick4(b, 145, 125, 120, 110);
            4'd4:    return pick4(b, 140, 120, 115, 105);
            4'd5:    return pick4(b, 145, 140, 130, 120);
            4'd6:    return pick4(b, 105, 100,  90,  85);
            4'd7:    return pick4(b,  75,  70,  65,  60);
            4'd8:    return pick4(b,  60,  55,  55,  50);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/ssc_sel_decode.sv
module ssc_sel_decode
    import ssc_pkg::*;
(
    input  logic [1:0]       s0_code,
    input  logic [1:0]       s1_code,
    output logic [SET_W-1:0] idx,
    output logic             hi,
    output logic             bad
);

    tl_code_e c0;
    tl_code_e c1;

    always_comb begin
        c0 = tl_clean(s0_code);
        c1 = tl_clean(s1_code);
        case ({c1, c0})
            {TL_MID, TL_MID}: idx = SET_W'(0);
            {TL_MID, TL_LO }: idx = SET_W'(1);
            {TL_HI,  TL_LO }: idx = SET_W'(2);
            {TL_LO,  TL_LO }: idx = SET_W'(3);
            {TL_LO,  TL_MID}: idx = SET_W'(4);
            {TL_HI,  TL_MID}: idx = SET_W'(5);
            {TL_LO,  TL_HI }: idx = SET_W'(6);
            {TL_HI,  TL_HI }: idx = SET_W'(7);
            {TL_MID, TL_HI }: idx = SET_W'(8);
            default:          idx = SET_W'(0);
        endcase
        hi  = (idx >= SET_W'(5));
        bad = (&s0_code) | (&s1_code);
    end

endmodule

// File: rtl/ssc_peak_lut.sv
module ssc_peak_lut
    import ssc_pkg::*;
(
    input  logic [SET_W-1:0]  idx,
    input  logic [BAND_W-1:0] band,
    output logic [PEAK_W-1:0] peak
);

    always_comb peak = peak_lookup(idx, band);

endmodule

// File: rtl/ssc_sweep_core.sv
module ssc_sweep_core
    import ssc_pkg::*;
#(
    parameter  int PERIOD = 1166,
    parameter  int OFF_W  = 10,
    localparam int PH_W   = $clog2(PERIOD),
    localparam int HALF   = PERIOD / 2,
    localparam int ACC_W  = $clog2(HALF + (2 << PEAK_W))
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cur_en,
    input  logic [PEAK_W-1:0]       cur_peak,
    input  logic                    nxt_en,
    input  logic [PEAK_W-1:0]       nxt_peak,
    output logic [PH_W-1:0]         phase,
    output logic                    wrap,
    output logic signed [OFF_W-1:0] offset
);

    logic [PH_W-1:0]         ph_q;
    logic [ACC_W-1:0]        acc_q;
    logic signed [OFF_W-1:0] off_q;
    logic [ACC_W-1:0]        acc_sum;
    logic                    carry;
    logic                    rising;

    // Error accumulator: adds 2P per cycle, emits a unit step on overflow
    // past HALF, so the ramp lands exactly on the peak after HALF cycles.
    assign acc_sum = acc_q + ACC_W'({cur_peak, 1'b0});
    assign carry   = (acc_sum >= ACC_W'(HALF));
    assign rising  = (ph_q < PH_W'(HALF));
    assign wrap    = (ph_q == PH_W'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            acc_q <= '0;
            off_q <= '0;
        end else if (wrap) begin
            ph_q  <= '0;
            acc_q <= '0;
            off_q <= nxt_en ? -$signed(OFF_W'(nxt_peak)) : '0;
        end else begin
            ph_q <= ph_q + PH_W'(1);
            if (!cur_en) begin
                acc_q <= '0;
                off_q <= '0;
            end else begin
                acc_q <= carry ? (acc_sum - ACC_W'(HALF)) : acc_sum;
                if (carry)
                    off_q <= rising ? (off_q + OFF_W'(1)) : (off_q - OFF_W'(1));
            end
        end
    end

    assign phase  = ph_q;
    assign offset = off_q;

endmodule

// File: rtl/ssc_mod_ctrl.sv
module ssc_mod_ctrl
    import ssc_pkg::*;
#(
    parameter int PERIOD = 1166,
    parameter int OFF_W  = 10
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spread_en_i,
    input  logic [1:0]              sel0_i,
    input  logic [1:0]              sel1_i,
    input  logic [BAND_W-1:0]       band_i,
    output logic signed [OFF_W-1:0] offset_o,
    output logic                    hi_range_o,
    output logic [SET_W-1:0]        setting_o,
    output logic [PEAK_W-1:0]       peak_o,
    output logic                    code_err_o
);

    localparam int PH_W = $clog2(PERIOD);

    logic [SET_W-1:0]  dec_idx;
    logic              dec_hi;
    logic              dec_bad;
    logic [PEAK_W-1:0] dec_peak;
    ssc_cfg_t          nxt_cfg;
    ssc_cfg_t          cfg_q;
    logic              err_q;
    logic [PH_W-1:0]   phase;
    logic              wrap;

    ssc_sel_decode u_dec (
        .s0_code (sel0_i),
        .s1_code (sel1_i),
        .idx     (dec_idx),
        .hi      (dec_hi),
        .bad     (dec_bad)
    );

    ssc_peak_lut u_lut (
        .idx  (dec_idx),
        .band (band_i),
        .peak (dec_peak)
    );

    always_comb begin
        nxt_cfg.en   = spread_en_i;
        nxt_cfg.hi   = dec_hi;
        nxt_cfg.idx  = dec_idx;
        nxt_cfg.band = band_i;
        nxt_cfg.peak = dec_peak;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.en   <= 1'b0;
            cfg_q.hi   <= 1'b0;
            cfg_q.idx  <= '0;
            cfg_q.band <= '0;
            cfg_q.peak <= peak_lookup(SET_W'(0), BAND_W'(0));
            err_q      <= 1'b0;
        end else begin
            if (wrap)
                cfg_q <= nxt_cfg;
            if (dec_bad)
                err_q <= 1'b1;
        end
    end

    ssc_sweep_core #(
        .PERIOD (PERIOD),
        .OFF_W  (OFF_W)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .cur_en   (cfg_q.en),
        .cur_peak (cfg_q.peak),
        .nxt_en   (nxt_cfg.en),
        .nxt_peak (nxt_cfg.peak),
        .phase    (phase),
        .wrap     (wrap),
        .offset   (offset_o)
    );

    assign hi_range_o = cfg_q.hi;
    assign setting_o  = cfg_q.idx;
    assign peak_o     = cfg_q.peak;
    assign code_err_o = err_q;

endmodule

// File: rtl/ssc_mod_ctrl_chk.sv
module ssc_mod_ctrl_chk
    import ssc_pkg::*;
#(
    parameter  int PERIOD = 1166,
    parameter  int OFF_W  = 10,
    localparam int PH_W   = $clog2(PERIOD),
    localparam int HALF   = PERIOD / 2
)(
    input logic                    clk,
    input logic                    rst,
    input logic [1:0]              sel0_i,
    input logic [1:0]              sel1_i,
    input logic                    act,
    input logic [PH_W-1:0]         phase,
    input logic signed [OFF_W-1:0] offset_o,
    input logic [PEAK_W-1:0]       peak_o,
    input logic [SET_W-1:0]        setting_o,
    input logic                    code_err_o
);

    logic signed [OFF_W-1:0] prev_off;
    logic signed [OFF_W:0]   step;
    logic signed [OFF_W:0]   peak_s;

    always_ff @(posedge clk) prev_off <= offset_o;

    assign step   = {offset_o[OFF_W-1], offset_o} - {prev_off[OFF_W-1], prev_off};
    assign peak_s = $signed((OFF_W + 1)'(peak_o));

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_W'(PERIOD - 1)) |=> (phase == '0));

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase < PH_W'(PERIOD));

    // R2
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != '0) |-> (step >= -1 && step <= 1));

    // R3
    low_peak_chk: assert property (@(posedge clk) disable iff (rst)
        (act && phase == '0) |-> (offset_o == -peak_s));

    // R3
    high_peak_chk: assert property (@(posedge clk) disable iff (rst)
        (act && phase == PH_W'(HALF)) |-> (offset_o == peak_s));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !act |-> (offset_o == '0));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != '0) |-> ($stable(setting_o) && $stable(peak_o)));

    // R6
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (sel0_i == 2'b11 || sel1_i == 2'b11) |=> code_err_o);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        code_err_o |=> code_err_o);

endmodule

bind ssc_mod_ctrl ssc_mod_ctrl_chk #(
    .PERIOD (PERIOD),
    .OFF_W  (OFF_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel0_i     (sel0_i),
    .sel1_i     (sel1_i),
    .act        (cfg_q.en),
    .phase      (phase),
    .offset_o   (offset_o),
    .peak_o     (peak_o),
    .setting_o  (setting_o),
    .code_err_o (code_err_o)
);

// File: tb/test_ssc_mod_ctrl.sv
module test_ssc_mod_ctrl;

    localparam int PER  = 1166;
    localparam int HALF = 583;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b1;
    logic [1:0]        s0  = 2'b01;
    logic [1:0]        s1  = 2'b01;
    logic [1:0]        band = 2'b00;
    logic signed [9:0] off;
    logic              hi;
    logic [3:0]        setv;
    logic [8:0]        pk;
    logic              err;

    always #10 clk = ~clk;

    ssc_mod_ctrl i_ssc_mod_ctrl (
        .clk         (clk),
        .rst         (rst),
        .spread_en_i (en),
        .sel0_i      (s0),
        .sel1_i      (s1),
        .band_i      (band),
        .offset_o    (off),
        .hi_range_o  (hi),
        .setting_o   (setv),
        .peak_o      (pk),
        .code_err_o  (err)
    );

    // R4 peak table, R5 code pairs (L=00, M=01, H=10)
    int         ptab [9][4] = '{'{215,195,185,170}, '{190,175,165,155}, '{170,155,140,130},
                                '{145,125,120,110}, '{140,120,115,105}, '{145,140,130,120},
                                '{105,100,90,85},   '{75,70,65,60},     '{60,55,55,50}};
    logic [1:0] c1tab [9] = '{2'b01,2'b01,2'b10,2'b00,2'b00,2'b10,2'b00,2'b10,2'b01};
    logic [1:0] c0tab [9] = '{2'b01,2'b00,2'b00,2'b00,2'b01,2'b01,2'b10,2'b10,2'b10};

    int checks = 0, errors = 0;
    bit done = 0;
    int m_ph = 0, m_act = 0, m_idx = 0, m_band = 0, m_err = 0;
    int d_idx = 0, d_band = 0, d_en = 1;
    bit d_bad = 0;
    int cyc = 0, last_evt = -1, prev_off = 0, mx = 0, mn = 0;

    function automatic int exp_off(int p, int pk_v);
        if (p <= HALF) return -pk_v + (2 * pk_v * p) / HALF;
        return pk_v - (2 * pk_v * (p - HALF)) / HALF;
    endfunction

    task automatic check(bit ok, string req, string what, int act_v, int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, act_v, exp_v, cyc);
        end
    endtask

    task automatic drive_cfg(int idx, int b, int e);
        s1 = c1tab[idx]; s0 = c0tab[idx]; band = 2'(b); en = (e != 0);
        d_idx = idx; d_band = b; d_en = e; d_bad = 0;
    endtask

    task automatic tick();
        int p, eo;
        // R3: period extremes, checked just before the boundary edge
        if (!rst && m_act != 0 && m_ph == PER - 1) begin
            p = ptab[m_idx][m_band];
            check(mx == p,  "R3", "period maximum", mx, p);
            check(mn == -p, "R3", "period minimum", mn, -p);
        end
        @(posedge clk);
        if (rst) begin
            m_ph = 0; m_act = 0; m_idx = 0; m_band = 0; m_err = 0;
        end else begin
            if (d_bad) m_err = 1;
            if (m_ph == PER - 1) begin
                m_ph = 0; m_act = d_en; m_idx = d_idx; m_band = d_band;
            end else m_ph++;
        end
        @(negedge clk);
        cyc++;
        p  = ptab[m_idx][m_band];
        eo = (m_act != 0) ? exp_off(m_ph, p) : 0;
        if (rst) begin
            check(int'(off) == 0, "R9", "offset in reset", int'(off), 0);
            check(int'(pk) == 215 && setv == 0, "R9", "peak in reset", int'(pk), 215);
        end else if (m_act != 0) begin
            check(int'(off) == eo, "R2", "offset", int'(off), eo);
        end else begin
            check(int'(off) == 0, "R7", "offset while disabled", int'(off), 0);
        end
        check(int'(setv) == m_idx, "R8", "setting index", int'(setv), m_idx);
        check(int'(hi) == int'(m_idx >= 5), "R5", "range flag", int'(hi), int'(m_idx >= 5));
        check(int'(pk) == p, "R4", "peak", int'(pk), p);
        check(int'(err) == m_err, "R6", "error flag", int'(err), m_err);
        // R1: spacing between entries into the negative peak
        if (m_act == 0 || rst) last_evt = -1;
        else if (int'(off) == -int'(pk) && int'(off) != prev_off) begin
            if (last_evt >= 0) check(cyc - last_evt == PER, "R1", "period length", cyc - last_evt, PER);
            last_evt = cyc;
        end
        if (m_ph == 0) begin mx = int'(off); mn = int'(off); end
        else begin
            if (int'(off) > mx) mx = int'(off);
            if (int'(off) < mn) mn = int'(off);
        end
        prev_off = int'(off);
    endtask

    task automatic wait_phase(int p);
        while (m_ph != p) tick();
    endtask

    initial begin
        drive_cfg(0, 0, 1);
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        // R9: first period after reset stays idle; R4/R5 sweep all settings
        for (int k = 0; k < 36; k++) begin
            wait_phase(PER - 1);
            tick();
            wait_phase(300);
            // R8: next configuration applied mid-sweep
            if (k < 35) drive_cfg((k + 1) / 4, (k + 1) % 4, 1);
            else        drive_cfg(0, 0, 0);
        end
        wait_phase(PER - 1);
        tick();
        // R7 disabled period; R8 re-enable mid-period must wait
        wait_phase(300);
        drive_cfg(3, 2, 1);
        wait_phase(PER - 1);
        tick();
        // R6: illegal code on sel0 decodes as middle, index 0
        wait_phase(300);
        s1 = 2'b01; s0 = 2'b11; band = 2'd1; en = 1'b1;
        d_idx = 0; d_band = 1; d_en = 1; d_bad = 1;
        wait_phase(PER - 1);
        tick();
        // R6: illegal code on sel1 with sel0 high decodes as (M,H), index 8
        wait_phase(300);
        s1 = 2'b11; s0 = 2'b10; band = 2'd3;
        d_idx = 8; d_band = 3; d_bad = 1;
        wait_phase(PER - 1);
        tick();
        wait_phase(100);
        drive_cfg(2, 3, 1);
        wait_phase(PER - 1);
        tick();
        // R9: reset in the middle of a sweep
        wait_phase(500);
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        check(err == 1'b0, "R9", "error cleared by reset", int'(err), 0);
        wait_phase(PER - 1);
        tick();
        wait_phase(PER - 1);
        tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: got %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule